// File: doc/BRIEF.md
# OLED Command Decoder and Window Addresser

This block sits behind a serial-peripheral byte receiver on a small greyscale OLED controller. Each byte arrives with a strobe and a select level: a low select means the byte is part of a command, a high select means it is pixel data. Command bytes are grouped into an opcode and the number of argument bytes that opcode needs. Once the last argument arrives, the command is applied. Only three commands change state here: the column window, the row window and the remap register. Every other known opcode is parsed and its arguments are dropped.

Pixel bytes are written to a frame memory that holds two 4-bit pixels per byte. The memory has a parameterised number of byte columns per row and of rows. The write position walks a programmable rectangle and wraps inside it. It advances either column-first or row-first, as set by one remap bit. A redraw flag tells the scan-out side that the memory has changed, and that side clears the flag when it has read the frame.

The byte input follows valid/ready rules. `in_ready` is held high because every byte is consumed in the cycle it is offered, so the block never applies back-pressure. A byte counts as transferred on any rising edge where `in_valid` is high.

Top module: `oled_cmd_window`

## Requirements
- R1: Each byte offered with `in_valid` high and `in_is_data` high produces exactly one memory write, with `mem_we` high in the next cycle. Command bytes never produce a write.
- R2: The write carries `mem_wdata` equal to the byte. `mem_addr` equals col + row*COLS, using the position held before that byte was accepted.
- R3: After reset, the column window is 0..COLS-1 and the row window is 0..ROWS-1, and the position is (0,0). `remap`, `redraw`, `mem_we` and `cmd_error` are all 0.
- R4: Opcode 0x15 takes two arguments. The first, modulo COLS, sets the column start and the current column. The second, modulo COLS, sets the column end.
- R5: Opcode 0x75 takes two arguments. The first, modulo ROWS, sets the row start and the current row. The second, modulo ROWS, sets the row end.
- R6: Opcode 0xA0 takes one argument, which is stored as `remap`. Bit 2 (value 0x04) of `remap` selects vertical increment.
- R7: With bit 2 clear, each write advances the column. When the column is at or past its end, the column reloads its start and the row advances. When the row is also at or past its end, the row reloads its start.
- R8: With bit 2 set, each write advances the row. When the row is at or past its end, the row reloads its start and the column advances. When the column is also at or past its end, the column reloads its start.
- R9: The following opcodes take one argument: 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE, 0xBF. Opcode 0xB8 takes eight arguments. The following take none: 0x84, 0x85, 0x86, 0xA4, 0xA5, 0xA6, 0xA7, 0xAE, 0xAF, 0xE3. Argument bytes are never taken as opcodes.
- R10: An opcode not listed in R4, R5, R6 or R9, other than 0xFF, completes with no arguments and raises `cmd_error` for exactly the following cycle. Opcode 0xFF completes with no arguments and no error.
- R11: Every data write sets `redraw`. `clear_redraw` clears it on the next edge, unless a data byte is accepted on that same edge, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe from the serial receiver |
| in_ready | output | 1 | Always high; the block accepts a byte every cycle |
| in_data | input | 8 | Received byte |
| in_is_data | input | 1 | 1 = pixel data byte, 0 = command byte |
| clear_redraw | input | 1 | Scan-out side has consumed the frame |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | $clog2(COLS*ROWS) | Frame memory byte address |
| mem_wdata | output | 8 | Frame memory write data (two pixels) |
| redraw | output | 1 | Frame changed since the last clear |
| remap | output | 8 | Current remap register |
| cmd_error | output | 1 | One-cycle pulse on an unknown opcode |

## Verification
The bench builds the block with the default COLS = 64 and ROWS = 80. Sizes smaller than 256 make the argument reduction visible, and a row count that is not a power of two checks that the reduction is a true modulo and not a bit mask. With only 5120 bytes in the frame, a full walk of the default window down to the wrap at (0,0) takes a few thousand cycles, so the bench drives the complete frame as well as small hand-placed windows in both increment orders.

// File: rtl/oled_win_pkg.sv
package oled_win_pkg;

  localparam int ARG_CNT_W = 4;

  localparam logic [7:0] OP_COL_WIN = 8'h15;
  localparam logic [7:0] OP_ROW_WIN = 8'h75;
  localparam logic [7:0] OP_REMAP   = 8'hA0;
  localparam logic [7:0] OP_FILLER  = 8'hFF;

  typedef struct packed {
    logic                 known;
    logic [ARG_CNT_W-1:0] nargs;
  } op_info_t;

  function automatic op_info_t op_lookup(input logic [7:0] op);
    op_info_t r;
    r.known = 1'b1;
    r.nargs = '0;
    case (op)
      OP_COL_WIN, OP_ROW_WIN:                  r.nargs = 4'd2;
      OP_REMAP, 8'h81, 8'hA1, 8'hA2, 8'hA8,
      8'hAD, 8'hB1, 8'hB2, 8'hB3, 8'hBC,
      8'hBE, 8'hBF:                            r.nargs = 4'd1;
      8'hB8:                                   r.nargs = 4'd8;
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5,
      8'hA6, 8'hA7, 8'hAE, 8'hAF, 8'hE3,
      OP_FILLER:                               r.nargs = 4'd0;
      default:                                 r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/oled_cmd_collect.sv
module oled_cmd_collect
  import oled_win_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic       apply_col,
  output logic       apply_row,
  output logic       apply_remap,
  output logic [7:0] arg_a,
  output logic [7:0] arg_b,
  output logic       err_pulse
);

  logic                 busy_q;
  logic [7:0]           op_q;
  logic [ARG_CNT_W-1:0] need_q;
  logic [ARG_CNT_W-1:0] got_q;
  logic [7:0]           first_q;
  op_info_t             info;
  logic                 last_arg;

  assign info     = op_lookup(cmd_byte);
  assign last_arg = cmd_valid && busy_q && ((got_q + ARG_CNT_W'(1)) == need_q);

  // First argument: live byte when the command has a single argument.
  assign arg_a = (got_q == '0) ? cmd_byte : first_q;
  assign arg_b = cmd_byte;

  assign apply_col   = last_arg && (op_q == OP_COL_WIN);
  assign apply_row   = last_arg && (op_q == OP_ROW_WIN);
  assign apply_remap = last_arg && (op_q == OP_REMAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_q      <= '0;
      need_q    <= '0;
      got_q     <= '0;
      first_q   <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= cmd_valid && !busy_q && !info.known;
      if (cmd_valid) begin
        if (!busy_q) begin
          if (info.nargs != '0) begin
            busy_q <= 1'b1;
            op_q   <= cmd_byte;
            need_q <= info.nargs;
            got_q  <= '0;
          end
        end else begin
          got_q <= got_q + ARG_CNT_W'(1);
          if (got_q == '0) first_q <= cmd_byte;
          if (last_arg) begin
            busy_q <= 1'b0;
            got_q  <= '0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/oled_win_addr.sv
module oled_win_addr #(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  parameter int VERT_BIT = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            set_col,
  input  logic                            set_row,
  input  logic                            set_remap,
  input  logic [7:0]                      arg_a,
  input  logic [7:0]                      arg_b,
  input  logic                            wr_valid,
  input  logic [7:0]                      wr_byte,
  output logic                            mem_we,
  output logic [$clog2(COLS*ROWS)-1:0]    mem_addr,
  output logic [7:0]                      mem_wdata,
  output logic [7:0]                      remap
);

  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int AW = $clog2(COLS*ROWS);

  logic [CW-1:0] col_q, col_start_q, col_end_q, col_n;
  logic [RW-1:0] row_q, row_start_q, row_end_q, row_n;
  logic          vertical;
  logic          col_at_end, row_at_end;

  assign vertical   = remap[VERT_BIT];
  assign col_at_end = col_q >= col_end_q;
  assign row_at_end = row_q >= row_end_q;

  always_comb begin
    col_n = col_q;
    row_n = row_q;
    if (vertical) begin
      if (row_at_end) begin
        row_n = row_start_q;
        col_n = col_at_end ? col_start_q : col_q + CW'(1);
      end else begin
        row_n = row_q + RW'(1);
      end
    end else begin
      if (col_at_end) begin
        col_n = col_start_q;
        row_n = row_at_end ? row_start_q : row_q + RW'(1);
      end else begin
        col_n = col_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q       <= '0;
      col_start_q <= '0;
      col_end_q   <= CW'(COLS - 1);
      row_q       <= '0;
      row_start_q <= '0;
      row_end_q   <= RW'(ROWS - 1);
      remap       <= '0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      mem_we <= wr_valid;
      if (wr_valid) begin
        mem_addr  <= AW'(32'(row_q) * COLS + 32'(col_q));
        mem_wdata <= wr_byte;
        col_q     <= col_n;
        row_q     <= row_n;
      end
      if (set_col) begin
        col_start_q <= CW'(32'(arg_a) % COLS);
        col_q       <= CW'(32'(arg_a) % COLS);
        col_end_q   <= CW'(32'(arg_b) % COLS);
      end
      if (set_row) begin
        row_start_q <= RW'(32'(arg_a) % ROWS);
        row_q       <= RW'(32'(arg_a) % ROWS);
        row_end_q   <= RW'(32'(arg_b) % ROWS);
      end
      if (set_remap) remap <= arg_a;
    end
  end

endmodule

// File: rtl/oled_redraw_flag.sv
module oled_redraw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

endmodule

// File: rtl/oled_cmd_window.sv
module oled_cmd_window #(
  parameter int COLS = 64,
  parameter int ROWS = 80
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [7:0]                   in_data,
  input  logic                         in_is_data,
  input  logic                         clear_redraw,
  output logic                         mem_we,
  output logic [$clog2(COLS*ROWS)-1:0] mem_addr,
  output logic [7:0]                   mem_wdata,
  output logic                         redraw,
  output logic [7:0]                   remap,
  output logic                         cmd_error
);

  logic       cmd_valid, dat_valid;
  logic       apply_col, apply_row, apply_remap;
  logic [7:0] arg_a, arg_b;

  assign in_ready  = 1'b1;
  assign cmd_valid = in_valid && !in_is_data;
  assign dat_valid = in_valid && in_is_data;

  oled_cmd_collect u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (in_data),
    .apply_col   (apply_col),
    .apply_row   (apply_row),
    .apply_remap (apply_remap),
    .arg_a       (arg_a),
    .arg_b       (arg_b),
    .err_pulse   (cmd_error)
  );

  oled_win_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_col   (apply_col),
    .set_row   (apply_row),
    .set_remap (apply_remap),
    .arg_a     (arg_a),
    .arg_b     (arg_b),
    .wr_valid  (dat_valid),
    .wr_byte   (in_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .remap     (remap)
  );

  oled_redraw_flag u_redraw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (dat_valid),
    .clr_req (clear_redraw),
    .flag    (redraw)
  );

endmodule

// File: rtl/oled_cmd_window_chk.sv
module oled_cmd_window_chk #(
  parameter int COLS = 64,
  parameter int ROWS = 80
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic [7:0]                   in_data,
  input logic                         in_is_data,
  input logic                         clear_redraw,
  input logic                         mem_we,
  input logic [$clog2(COLS*ROWS)-1:0] mem_addr,
  input logic [7:0]                   mem_wdata,
  input logic                         redraw,
  input logic                         cmd_error
);

  p_write_follows_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_data) |=> mem_we);

  p_write_has_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && in_is_data));

  p_wdata_is_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == $past(in_data)));

  p_addr_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(mem_addr) < COLS * ROWS));

  p_error_from_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> $past(in_valid && !in_is_data));

  p_redraw_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_data) |=> redraw);

  p_redraw_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_redraw && !(in_valid && in_is_data)) |=> !redraw);

endmodule

bind oled_cmd_window oled_cmd_window_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .in_is_data   (in_is_data),
  .clear_redraw (clear_redraw),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .redraw       (redraw),
  .cmd_error    (cmd_error)
);

// File: tb/test_oled_cmd_window.sv
module test_oled_cmd_window;

  localparam int CLK_PERIOD = 10;
  localparam int COLS = 64;
  localparam int ROWS = 80;
  localparam int AW = $clog2(COLS*ROWS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          in_is_data = 1'b0;
  logic          clear_redraw = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          redraw;
  logic [7:0]    remap;
  logic          cmd_error;

  int checks = 0;
  int errors = 0;
  int err_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oled_cmd_window #(.COLS(COLS), .ROWS(ROWS)) i_oled_cmd_window (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_data(in_is_data), .clear_redraw(clear_redraw),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redraw(redraw), .remap(remap), .cmd_error(cmd_error)
  );

  always @(negedge clk) if (rst_n && cmd_error) err_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one byte for one cycle; returns at the negedge after the accepting edge.
  task automatic push(input logic [7:0] b, input logic is_data, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_is_data = is_data; clear_redraw = clr;
    @(negedge clk);
    in_valid = 1'b0; in_is_data = 1'b0; clear_redraw = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    push(b, 1'b0, 1'b0);
  endtask

  task automatic wr_expect(input logic [7:0] b, input int exp_addr, input string req);
    push(b, 1'b1, 1'b0);
    check(mem_we === 1'b1, req, int'(mem_we), 1);
    check(int'(mem_addr) == exp_addr, req, int'(mem_addr), exp_addr);
  endtask

  task automatic t_reset;
    check(remap == 8'h00, "R3 remap", int'(remap), 0);
    check(redraw == 1'b0, "R3 redraw", int'(redraw), 0);
    check(mem_we == 1'b0, "R3 mem_we", int'(mem_we), 0);
    check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    cmd(8'h15);
    check(mem_we == 1'b0, "R1 no write on command", int'(mem_we), 0);
    cmd(8'h00); cmd(8'h3F);
    push(8'h5A, 1'b1, 1'b0);
    check(mem_wdata == 8'h5A, "R2 wdata", int'(mem_wdata), 8'h5A);
    check(mem_addr == '0, "R2 first addr", int'(mem_addr), 0);
  endtask

  task automatic t_full_frame;
    // Fresh default window: walk the whole frame.
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < COLS*ROWS; i++) begin
      push(8'(i), 1'b1, 1'b0);
      if (i == COLS) check(int'(mem_addr) == COLS, "R3 col end 63", int'(mem_addr), COLS);
      if (i == COLS*ROWS-1)
        check(int'(mem_addr) == COLS*ROWS-1, "R3 last addr", int'(mem_addr), COLS*ROWS-1);
    end
    wr_expect(8'hEE, 0, "R3 frame wrap");
  endtask

  task automatic t_horizontal;
    cmd(8'hA0); cmd(8'h00);
    cmd(8'h15); cmd(8'h42); cmd(8'h44);   // 66%64=2, 68%64=4
    cmd(8'h75); cmd(8'd90); cmd(8'd91);   // 90%80=10, 91%80=11
    wr_expect(8'h01, 10*64+2, "R4 R5 start");
    wr_expect(8'h02, 10*64+3, "R7 step");
    wr_expect(8'h03, 10*64+4, "R7 step");
    wr_expect(8'h04, 11*64+2, "R7 col wrap");
    wr_expect(8'h05, 11*64+3, "R7 step");
    wr_expect(8'h06, 11*64+4, "R7 step");
    wr_expect(8'h07, 10*64+2, "R7 row wrap");
  endtask

  task automatic t_vertical;
    cmd(8'hA0); cmd(8'h04);
    check(remap == 8'h04, "R6 remap", int'(remap), 4);
    cmd(8'h15); cmd(8'd2); cmd(8'd3);
    cmd(8'h75); cmd(8'd10); cmd(8'd11);
    wr_expect(8'h11, 10*64+2, "R8 start");
    wr_expect(8'h12, 11*64+2, "R8 row step");
    wr_expect(8'h13, 10*64+3, "R8 row wrap");
    wr_expect(8'h14, 11*64+3, "R8 row step");
    wr_expect(8'h15, 10*64+2, "R8 col wrap");
  endtask

  task automatic t_arg_counts;
    int e0;
    e0 = err_seen;
    cmd(8'hA0); cmd(8'h00);
    cmd(8'h81); cmd(8'h15);                 // argument, not opcode
    cmd(8'hA8); cmd(8'hA0);                 // argument, not opcode
    cmd(8'hB8);
    for (int i = 0; i < 8; i++) cmd(8'h75);
    cmd(8'hA4); cmd(8'hE3); cmd(8'hAF); cmd(8'h85);
    check(remap == 8'h00, "R9 remap untouched", int'(remap), 0);
    cmd(8'h15); cmd(8'd5); cmd(8'd5);
    cmd(8'h75); cmd(8'd1); cmd(8'd1);
    wr_expect(8'h21, 64+5, "R9 alignment after skips");
    check(err_seen == e0, "R9 no error", err_seen - e0, 0);
  endtask

  task automatic t_unknown;
    int e0;
    cmd(8'h00);
    check(cmd_error == 1'b1, "R10 error pulse", int'(cmd_error), 1);
    @(negedge clk);
    check(cmd_error == 1'b0, "R10 pulse one cycle", int'(cmd_error), 0);
    cmd(8'h15); cmd(8'd7); cmd(8'd7);
    wr_expect(8'h31, 64+7, "R10 opcode after unknown");
    e0 = err_seen;
    cmd(8'hFF);
    check(cmd_error == 1'b0, "R10 filler no error", int'(cmd_error), 0);
    cmd(8'h15); cmd(8'd9); cmd(8'd9);
    wr_expect(8'h32, 64+9, "R10 filler takes no args");
    check(err_seen == e0, "R10 filler count", err_seen - e0, 0);
  endtask

  task automatic t_redraw;
    push(8'h00, 1'b0, 1'b1);   // NOP-free: 0x00 unknown is fine, clear rides along
    check(redraw == 1'b0, "R11 clear", int'(redraw), 0);
    push(8'h41, 1'b1, 1'b1);
    check(redraw == 1'b1, "R11 set wins", int'(redraw), 1);
    push(8'hE3, 1'b0, 1'b1);
    check(redraw == 1'b0, "R11 clear again", int'(redraw), 0);
    push(8'h42, 1'b1, 1'b0);
    check(redraw == 1'b1, "R11 set on write", int'(redraw), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_frame();
    t_horizontal();
    t_vertical();
    t_arg_counts();
    t_unknown();
    t_redraw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule